// File: doc/BRIEF.md
# Indexed Configuration Register Window

This block gives a host a two-address window into a private file of 256 byte-wide configuration registers. The host first writes a register number to the index port, then reads or writes the chosen byte through the data port. Only some register numbers accept writes. The rest hold their reset value forever, and writes aimed at them are dropped without any sign. A few registers carry fixed non-zero reset values. Four of them hold base-address bytes for legacy peripherals, and these are driven out in parallel so that nearby logic can use them.

The window answers only while the parent bridge holds `win_en` high. It comes out of reset with the index at zero. A read at either port address returns the byte that the current index selects, so the index itself can never be read back. Every access is a single byte.

The host side is a plain strobe bus with no back-pressure. A strobe lasts one clock cycle. `io_ack` and `io_rdata` answer exactly one cycle later and are never stalled. The host must not assert `io_wr` and `io_rd` in the same cycle.

Top module: `cfgwin_top`

## Requirements
- R1: After reset the index is 0x00. Register 0xE0 holds 0x3C, 0xE2 holds 0x03, 0xE3 holds 0xFC, 0xE6 holds 0xDE, 0xE7 holds 0xFE and 0xE8 holds 0xBE. Every other register holds 0x00, `io_ack` is 0 and `io_rdata` is 0xFF.
- R2: An enabled write strobe at address 0x03F0 (the index port) makes the write byte the current index.
- R3: An enabled write strobe at address 0x03F1 (the data port) stores the write byte in the selected register when that register is writable. The writable registers are 0xE0-0xE3, 0xE6-0xE8, 0xEE-0xF2, 0xF4, 0xF6, 0xF8 and 0xFC.
- R4: A data-port write to any register not listed in R3 leaves every register unchanged.
- R5: An enabled read strobe at either 0x03F0 or 0x03F1 returns the register selected by the current index on `io_rdata`, with `io_ack` high, one clock after the strobe.
- R6: While `win_en` is 0, write strobes change neither the index nor any register. Read strobes return 0xFF one clock later with `io_ack` low.
- R7: Strobes at any address other than 0x03F0 and 0x03F1 have no effect, produce no `io_ack`, and return 0xFF.
- R8: `floppy_base`, `par_base`, `ser1_base` and `ser2_base` always show registers 0xE3, 0xE6, 0xE7 and 0xE8.
- R9: Data-port reads and writes leave the current index unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| win_en | input | 1 | Window decode enable from the parent bridge |
| io_addr | input | 16 | I/O address of the access |
| io_wr | input | 1 | Single-cycle write strobe |
| io_rd | input | 1 | Single-cycle read strobe |
| io_wdata | input | 8 | Write byte |
| io_rdata | output | 8 | Read byte, registered |
| io_ack | output | 1 | Access accepted, one cycle after the strobe |
| floppy_base | output | 8 | Register 0xE3 |
| par_base | output | 8 | Register 0xE6 |
| ser1_base | output | 8 | Register 0xE7 |
| ser2_base | output | 8 | Register 0xE8 |

## Verification
The hardest thing to observe is a dropped write to a read-only register. Such a write leaves no trace at the ports unless the same register is read back afterwards. The bench therefore sweeps all 256 indices: it writes a pattern that depends on the index, reads every register back, and compares each byte with its own model of the writable set. Writes made while the window is disabled are checked the same way: the bench re-enables the window and reads the index and the target register through the normal ports.

// File: rtl/cfgwin_pkg.sv
package cfgwin_pkg;
  localparam int unsigned IDX_W = 8;
  localparam int unsigned DEPTH = 1 << IDX_W;

  localparam logic [IDX_W-1:0] ID_IDX     = 8'hE0;
  localparam logic [IDX_W-1:0] FSEL_IDX   = 8'hE2;
  localparam logic [IDX_W-1:0] FLOPPY_IDX = 8'hE3;
  localparam logic [IDX_W-1:0] PAR_IDX    = 8'hE6;
  localparam logic [IDX_W-1:0] SER1_IDX   = 8'hE7;
  localparam logic [IDX_W-1:0] SER2_IDX   = 8'hE8;

  function automatic bit cfg_writable(input int unsigned i);
    case (i)
      'hE0, 'hE1, 'hE2, 'hE3, 'hE6, 'hE7, 'hE8,
      'hEE, 'hEF, 'hF0, 'hF1, 'hF2, 'hF4, 'hF6, 'hF8, 'hFC: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [7:0] cfg_default(input int unsigned i);
    case (i)
      'hE0: return 8'h3C;
      'hE2: return 8'h03;
      'hE3: return 8'hFC;
      'hE6: return 8'hDE;
      'hE7: return 8'hFE;
      'hE8: return 8'hBE;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/cfgwin_decode.sv
module cfgwin_decode #(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h03F0
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  input  logic              en,
  output logic              idx_we,
  output logic              dat_we,
  output logic              rd_hit
);
  localparam logic [ADDR_W-1:0] DATA_ADDR = BASE_ADDR + 1'b1;

  logic at_idx, at_dat;

  always_comb begin
    at_idx = (addr == BASE_ADDR);
    at_dat = (addr == DATA_ADDR);
    idx_we = en && wr && at_idx;
    dat_we = en && wr && at_dat;
    rd_hit = en && rd && (at_idx || at_dat);
  end
endmodule

// File: rtl/cfgwin_regfile.sv
module cfgwin_regfile
  import cfgwin_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic [7:0]       wdata,
  output logic [7:0]       rd_byte,
  output logic [7:0]       floppy_base,
  output logic [7:0]       par_base,
  output logic [7:0]       ser1_base,
  output logic [7:0]       ser2_base
);
  logic [7:0] q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    if (cfg_writable(g)) begin : g_rw
      logic [7:0] ent;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           ent <= cfg_default(g);
        else if (we && idx == IDX_W'(g))      ent <= wdata;
      end
      assign q[g] = ent;
    end else begin : g_ro
      assign q[g] = cfg_default(g);
    end
  end

  assign rd_byte     = q[idx];
  assign floppy_base = q[FLOPPY_IDX];
  assign par_base    = q[PAR_IDX];
  assign ser1_base   = q[SER1_IDX];
  assign ser2_base   = q[SER2_IDX];

  assert_wr_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (we && cfg_writable(32'(idx))) |=> rd_byte == $past(wdata));
  assert_ro_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !cfg_writable(32'(idx))) |=> rd_byte == $past(rd_byte));
endmodule

// File: rtl/cfgwin_readback.sv
module cfgwin_readback (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       acc_hit,
  input  logic       rd_hit,
  input  logic       rd_any,
  input  logic       win_en,
  input  logic [7:0] rd_byte,
  output logic [7:0] rdata,
  output logic       ack
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= 8'hFF;
      ack   <= 1'b0;
    end else begin
      ack <= acc_hit;
      if (rd_hit)      rdata <= rd_byte;
      else if (rd_any) rdata <= 8'hFF;
    end
  end

  assert_ack_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> $past(acc_hit));
  assert_off_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_any && !win_en) |=> (rdata == 8'hFF && !ack));
endmodule

// File: rtl/cfgwin_top.sv
module cfgwin_top
  import cfgwin_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h03F0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              win_en,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  output logic              io_ack,
  output logic [7:0]        floppy_base,
  output logic [7:0]        par_base,
  output logic [7:0]        ser1_base,
  output logic [7:0]        ser2_base
);
  logic             idx_we, dat_we, rd_hit;
  logic [IDX_W-1:0] cur_idx;
  logic [7:0]       rd_byte;

  cfgwin_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
    .addr(io_addr), .wr(io_wr), .rd(io_rd), .en(win_en),
    .idx_we(idx_we), .dat_we(dat_we), .rd_hit(rd_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cur_idx <= '0;
    else if (idx_we) cur_idx <= io_wdata[IDX_W-1:0];
  end

  cfgwin_regfile u_rf (
    .clk(clk), .rst_n(rst_n), .we(dat_we), .idx(cur_idx), .wdata(io_wdata),
    .rd_byte(rd_byte), .floppy_base(floppy_base), .par_base(par_base),
    .ser1_base(ser1_base), .ser2_base(ser2_base)
  );

  cfgwin_readback u_rb (
    .clk(clk), .rst_n(rst_n), .acc_hit(idx_we || dat_we || rd_hit),
    .rd_hit(rd_hit), .rd_any(io_rd), .win_en(win_en), .rd_byte(rd_byte),
    .rdata(io_rdata), .ack(io_ack)
  );

  assert_idx_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    idx_we |=> cur_idx == $past(io_wdata[IDX_W-1:0]));
  assert_idx_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !idx_we |=> $stable(cur_idx));
endmodule

// File: tb/cfgwin_top_bench.sv
module cfgwin_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] IXP = 16'h03F0;
  localparam logic [15:0] DTP = 16'h03F1;

  logic clk = 0, rst_n = 0, win_en = 0, io_wr = 0, io_rd = 0, io_ack;
  logic [15:0] io_addr = '0;
  logic [7:0] io_wdata = '0, io_rdata, floppy_base, par_base, ser1_base, ser2_base;
  logic [7:0] model [256];
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfgwin_top u_cfgwin_top (
    .clk(clk), .rst_n(rst_n), .win_en(win_en), .io_addr(io_addr), .io_wr(io_wr),
    .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata), .io_ack(io_ack),
    .floppy_base(floppy_base), .par_base(par_base), .ser1_base(ser1_base),
    .ser2_base(ser2_base)
  );

  function automatic bit tb_writable(int i);
    return (i >= 'hE0 && i <= 'hE3) || (i >= 'hE6 && i <= 'hE8) ||
           (i >= 'hEE && i <= 'hF2) || i == 'hF4 || i == 'hF6 || i == 'hF8 || i == 'hFC;
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [15:0] a, logic [7:0] d);
    @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1;
    @(negedge clk); io_wr = 0;
  endtask

  task automatic bus_rd(logic [15:0] a, output logic [7:0] d, output logic k);
    @(negedge clk); io_addr = a; io_rd = 1;
    @(negedge clk); io_rd = 0; d = io_rdata; k = io_ack;
  endtask

  task automatic rd_reg(logic [7:0] i, string req, logic [7:0] exp);
    logic [7:0] d; logic k;
    bus_wr(IXP, i);
    bus_rd(DTP, d, k);
    check(req, d, exp);
    check(req, {7'd0, k}, 8'd1);
  endtask

  task automatic t_reset();
    check("R1 ack", {7'd0, io_ack}, 8'd0);
    check("R1 rdata", io_rdata, 8'hFF);
    win_en = 1;
    for (int i = 0; i < 256; i++) begin
      model[i] = 8'h00;
      case (i)
        'hE0: model[i] = 8'h3C; 'hE2: model[i] = 8'h03; 'hE3: model[i] = 8'hFC;
        'hE6: model[i] = 8'hDE; 'hE7: model[i] = 8'hFE; 'hE8: model[i] = 8'hBE;
        default: ;
      endcase
    end
    for (int i = 0; i < 256; i++) rd_reg(8'(i), "R1 default", model[i]);
    check("R8 floppy", floppy_base, 8'hFC);
    check("R8 par", par_base, 8'hDE);
    check("R8 ser1", ser1_base, 8'hFE);
    check("R8 ser2", ser2_base, 8'hBE);
  endtask

  task automatic t_index_port_read();
    logic [7:0] d; logic k;
    bus_wr(IXP, 8'hE7);
    bus_rd(IXP, d, k);
    check("R5 read at index port", d, model['hE7]);
    check("R5 ack", {7'd0, k}, 8'd1);
    bus_wr(IXP, 8'h10);
    bus_rd(IXP, d, k);
    check("R2 index not returned", d, 8'h00);
  endtask

  task automatic t_sweep();
    for (int i = 0; i < 256; i++) begin
      bus_wr(IXP, 8'(i));
      bus_wr(DTP, 8'(i) ^ 8'h5A);
      if (tb_writable(i)) model[i] = 8'(i) ^ 8'h5A;
    end
    for (int i = 0; i < 256; i++)
      rd_reg(8'(i), tb_writable(i) ? "R3 writable" : "R4 read-only", model[i]);
    check("R8 floppy", floppy_base, model['hE3]);
    check("R8 par", par_base, model['hE6]);
    check("R8 ser1", ser1_base, model['hE7]);
    check("R8 ser2", ser2_base, model['hE8]);
  endtask

  task automatic t_index_persist();
    logic [7:0] d; logic k;
    bus_wr(IXP, 8'hF4);
    bus_wr(DTP, 8'h11);
    bus_rd(DTP, d, k);
    bus_wr(DTP, 8'h22);
    model['hF4] = 8'h22;
    bus_rd(DTP, d, k);
    check("R9 index kept", d, 8'h22);
  endtask

  task automatic t_disabled();
    logic [7:0] d; logic k;
    bus_wr(IXP, 8'hE6);
    win_en = 0;
    bus_wr(DTP, 8'h77);
    bus_wr(IXP, 8'hF6);
    bus_rd(DTP, d, k);
    check("R6 disabled rdata", d, 8'hFF);
    check("R6 disabled ack", {7'd0, k}, 8'd0);
    win_en = 1;
    bus_rd(DTP, d, k);
    check("R6 index unchanged", d, model['hE6]);
    check("R6 par unchanged", par_base, model['hE6]);
  endtask

  task automatic t_other_addr();
    logic [7:0] d; logic k;
    bus_wr(IXP, 8'hFC);
    bus_wr(16'h03F2, 8'h99);
    bus_wr(16'h13F0, 8'hE0);
    bus_rd(16'h03F2, d, k);
    check("R7 foreign rdata", d, 8'hFF);
    check("R7 foreign ack", {7'd0, k}, 8'd0);
    bus_rd(DTP, d, k);
    check("R7 index untouched", d, model['hFC]);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_index_port_read();
    t_sweep();
    t_index_persist();
    t_disabled();
    t_other_addr();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule